// File: doc/BRIEF.md
# SPI Supervisor Command Front End

This block is the serial command interface of a supply supervisor. It runs on the chip's system clock and oversamples the serial pins (chip select, serial clock, serial data in) plus the hardware write-protect pin through a synchronizer. It assembles opcodes and data bytes, runs a small command state machine, keeps a write-enable latch and a configuration register, and sends the status byte back on a serial output with its own output enable. The watchdog timeout selection, the block-protect field, the protect-enable bit and the write-enable latch are exported as plain outputs for the rest of the supervisor.

Mode 0 signalling is used: data in is taken on the rising serial clock edge, data out changes on the falling edge, and every byte moves most significant bit first. The synchronizer reports no edge until its pipeline has filled after reset. A chip-select level that is low when reset ends therefore does not open a command. The first falling edge of chip select has to be seen before anything is decoded.

States: `ST_IDLE` (deselected or waiting), `ST_OPCODE` (receiving the command byte), `ST_WRDATA` (receiving the status data byte), `ST_WRHOLD` (data byte complete, waiting for the chip-select rise), `ST_RDOUT` (sending status) and `ST_SKIP` (ignore everything until deselect). Transitions:
- IDLE→OPCODE on a chip-select fall.
- OPCODE→SKIP after the latch-set or latch-clear opcode, or after an unknown opcode.
- OPCODE→RDOUT after the status-read opcode.
- OPCODE→WRDATA after the status-write opcode.
- WRDATA→WRHOLD after eight data bits.
- WRHOLD→IDLE with commit on a chip-select rise.
- WRHOLD→SKIP on a further serial clock rise.
- Any active state→IDLE on a chip-select rise.

Top module: `spi_sup_front`

## Requirements
- R1: After reset the protect-enable bit, the watchdog select, the block-protect field and the write-enable latch all read 0, and `so_oe` is low.
- R2: No command is decoded until chip select has made a high-to-low transition after reset. A byte clocked in while chip select has been held low since reset has no effect.
- R3: Serial data is taken on rising serial clock edges, MSB first. Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it, as soon as the eighth opcode bit arrives.
- R4: Opcode 0x05 sends the status byte on `so`, MSB first, changing after falling serial clock edges. The layout is bit7 protect-enable, bit6 0, bits5:4 watchdog select, bits3:2 block protect, bit1 write-enable latch, bit0 busy (always 0). `so_oe` is high only during this read while chip select is low.
- R5: During a status read, the status byte is sent again for every further group of eight serial clocks, for as long as chip select stays low.
- R6: Opcode 0x01 followed by one data byte, with chip select rising right after the eighth data bit and the latch set, loads data bit7 into protect-enable, bits5:4 into the watchdog select and bits3:2 into block protect. Data bits 6, 1 and 0 are ignored.
- R7: The write-enable latch is cleared at the end of every completed status write attempt, including a locked one.
- R8: A completed status write while the latch is clear leaves the register unchanged.
- R9: While protect-enable is 1 and `wp_n` is low, a completed status write changes no field of the register.
- R10: If chip select rises in the middle of a byte, that byte is discarded. A partial opcode executes nothing, and a partial data byte changes neither the register nor the latch.
- R11: A serial clock rise after the eighth data bit of a status write cancels the write. Register and latch stay unchanged.
- R12: An unknown opcode is ignored up to the next chip-select rise. It changes no state and never raises `so_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Hardware write-protect, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| wdt_sel | output | 2 | Watchdog timeout selection |
| blk_prot | output | 2 | Block-protect field |
| wp_en | output | 1 | Protect-enable bit |
| wr_en_latch | output | 1 | Write-enable latch |

## Verification
The bench holds chip select low through reset and clocks in a latch-set opcode. A design that treats the synchronizer filling as a falling edge would set the latch there. Chip select is also raised after five bits of an opcode and after five bits of a data byte, and one extra clock is added after a full data byte. A design that keeps stale bit counts, or that commits on any chip-select rise, would then change the register or drop the latch. Status reads run over three consecutive bytes, so a serializer that fails to reload would send zeros after the first byte. Writes are also attempted under the hardware lock and with the latch clear, where a wrong lock or latch gate would let the fields change.

// File: rtl/spi_sup_pkg.sv
package spi_sup_pkg;

    localparam logic [7:0] CMD_LATCH_SET = 8'h06;
    localparam logic [7:0] CMD_LATCH_CLR = 8'h04;
    localparam logic [7:0] CMD_STAT_RD   = 8'h05;
    localparam logic [7:0] CMD_STAT_WR   = 8'h01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_WRDATA,
        ST_WRHOLD,
        ST_RDOUT,
        ST_SKIP
    } fe_state_t;

    typedef struct packed {
        logic       wpen;
        logic [1:0] wdsel;
        logic [1:0] bprot;
    } cfg_t;

endpackage

// File: rtl/spi_sup_sync.sv
module spi_sup_sync #(
    parameter int                 WIDTH   = 4,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    localparam int FW = $clog2(STAGES + 2);

    logic [STAGES-1:0][WIDTH-1:0] pipe_q;
    logic [WIDTH-1:0]             prev_q;
    logic [FW-1:0]                fill_q;
    logic                         full;

    assign full = (fill_q == FW'(STAGES + 1));
    assign lvl  = pipe_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {STAGES{RST_VAL}};
            prev_q <= RST_VAL;
            fill_q <= '0;
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], din};
            prev_q <= pipe_q[STAGES-1];
            if (!full) fill_q <= fill_q + 1'b1;
        end
    end

    assign rise = full ? (lvl & ~prev_q) : '0;
    assign fall = full ? (~lvl & prev_q) : '0;

endmodule

// File: rtl/spi_sup_rx.sv
module spi_sup_rx #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            shift_en,
    input  logic            din,
    output logic [BITS-1:0] data,
    output logic            done
);
    localparam int CW = $clog2(BITS);

    logic [CW-1:0]   cnt_q;
    logic [BITS-1:0] sh_q;
    logic            done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sh_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (clr) begin
                cnt_q <= '0;
            end else if (shift_en) begin
                sh_q <= {sh_q[BITS-2:0], din};
                if (cnt_q == CW'(BITS - 1)) begin
                    cnt_q  <= '0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign data = sh_q;
    assign done = done_q;

    AST_DONE_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R3

endmodule

// File: rtl/spi_sup_front.sv
module spi_sup_front
    import spi_sup_pkg::*;
#(
    parameter int BITS        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       si,
    input  logic       wp_n,
    output logic       so,
    output logic       so_oe,
    output logic [1:0] wdt_sel,
    output logic [1:0] blk_prot,
    output logic       wp_en,
    output logic       wr_en_latch
);
    localparam int NPIN = 4;
    localparam int TW   = $clog2(BITS);

    logic [NPIN-1:0] pin_lvl, pin_rise, pin_fall;
    logic cs_s, cs_fall, cs_rise, sck_rise, sck_fall, si_s, wp_s;

    spi_sup_sync #(
        .WIDTH  (NPIN),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b1001)
    ) u_sync (
        .clk (clk),
        .rst_n(rst_n),
        .din ({wp_n, si, sck, cs_n}),
        .lvl (pin_lvl),
        .rise(pin_rise),
        .fall(pin_fall)
    );

    assign cs_s     = pin_lvl[0];
    assign cs_fall  = pin_fall[0];
    assign cs_rise  = pin_rise[0];
    assign sck_rise = pin_rise[1];
    assign sck_fall = pin_fall[1];
    assign si_s     = pin_lvl[2];
    assign wp_s     = pin_lvl[3];

    fe_state_t       state_q, state_d;
    cfg_t            cfg_q;
    logic            wel_q;
    logic [BITS-1:0] rx_byte;
    logic            rx_done, rx_shift;
    logic            set_wel, clr_wel, commit, locked;
    logic [TW-1:0]   tx_cnt_q;
    logic [BITS-2:0] tx_sh_q;
    logic            so_q;
    logic [BITS-1:0] stat_byte;

    assign rx_shift = sck_rise && !cs_s &&
                      (state_q == ST_OPCODE || state_q == ST_WRDATA);

    spi_sup_rx #(.BITS(BITS)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cs_fall | cs_rise),
        .shift_en(rx_shift),
        .din     (si_s),
        .data    (rx_byte),
        .done    (rx_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and command strobes
    always_comb begin
        state_d = state_q;
        set_wel = 1'b0;
        clr_wel = 1'b0;
        commit  = 1'b0;
        unique case (state_q)
            ST_IDLE:   if (cs_fall) state_d = ST_OPCODE;
            ST_OPCODE: begin
                if (cs_rise) begin
                    state_d = ST_IDLE;
                end else if (rx_done) begin
                    case (rx_byte)
                        CMD_LATCH_SET: begin set_wel = 1'b1; state_d = ST_SKIP; end
                        CMD_LATCH_CLR: begin clr_wel = 1'b1; state_d = ST_SKIP; end
                        CMD_STAT_RD:   state_d = ST_RDOUT;
                        CMD_STAT_WR:   state_d = ST_WRDATA;
                        default:       state_d = ST_SKIP;
                    endcase
                end
            end
            ST_WRDATA: begin
                if (cs_rise)      state_d = ST_IDLE;
                else if (rx_done) state_d = ST_WRHOLD;
            end
            ST_WRHOLD: begin
                if (cs_rise) begin
                    commit  = 1'b1;
                    state_d = ST_IDLE;
                end else if (sck_rise) begin
                    state_d = ST_SKIP;
                end
            end
            ST_RDOUT:  if (cs_rise) state_d = ST_IDLE;
            ST_SKIP:   if (cs_rise) state_d = ST_IDLE;
        endcase
    end

    assign locked = cfg_q.wpen && !wp_s;

    // status register and write-enable latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            wel_q <= 1'b0;
        end else if (commit) begin
            wel_q <= 1'b0;
            if (wel_q && !locked)
                cfg_q <= '{wpen: rx_byte[7], wdsel: rx_byte[5:4], bprot: rx_byte[3:2]};
        end else if (set_wel) begin
            wel_q <= 1'b1;
        end else if (clr_wel) begin
            wel_q <= 1'b0;
        end
    end

    assign stat_byte = {cfg_q.wpen, 1'b0, cfg_q.wdsel, cfg_q.bprot, wel_q, 1'b0};

    // status serializer, reloads every byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_cnt_q <= '0;
            tx_sh_q  <= '0;
            so_q     <= 1'b0;
        end else if (state_q != ST_RDOUT) begin
            tx_cnt_q <= '0;
        end else if (sck_fall) begin
            if (tx_cnt_q == '0) {so_q, tx_sh_q} <= stat_byte;
            else                {so_q, tx_sh_q} <= {tx_sh_q, 1'b0};
            tx_cnt_q <= tx_cnt_q + 1'b1;
        end
    end

    assign so          = so_q;
    assign so_oe       = (state_q == ST_RDOUT) && !cs_s;
    assign wdt_sel     = cfg_q.wdsel;
    assign blk_prot    = cfg_q.bprot;
    assign wp_en       = cfg_q.wpen;
    assign wr_en_latch = wel_q;

    AST_IDLE_NEEDS_CS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !cs_fall) |=> state_q == ST_IDLE); // R2
    AST_SO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall |=> $stable(so_q)); // R4
    AST_OE_DROPS_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !so_oe); // R4
    AST_WEL_CLEARED_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRHOLD && cs_rise) |=> !wel_q); // R7
    AST_LOCK_HOLDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && state_q == ST_WRHOLD && cs_rise) |=> $stable(cfg_q)); // R9
    AST_EXTRA_CLOCK_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRHOLD && sck_rise && !cs_rise) |=> ($stable(cfg_q) && $stable(wel_q))); // R11

endmodule

// File: tb/spi_sup_front_tb.sv
module spi_sup_front_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b0;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic wp_n = 1'b1;
    logic so, so_oe, wp_en, wr_en_latch;
    logic [1:0] wdt_sel, blk_prot;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int oe_cnt = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] acc = '0;
    int         nb = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_sup_front u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .wp_n(wp_n),
        .so(so), .so_oe(so_oe), .wdt_sel(wdt_sel), .blk_prot(blk_prot),
        .wp_en(wp_en), .wr_en_latch(wr_en_latch)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    // {wpen, wdsel, bprot, wel}
    task automatic chk_regs(input logic [5:0] expv, input string tag);
        logic [5:0] act;
        act = {wp_en, wdt_sel, blk_prot, wr_en_latch};
        chk(act === expv, tag, int'(act), int'(expv));
    endtask

    task automatic bit_out(input logic b);
        @(negedge clk); sck = 1'b0; si = b;
        repeat (HALF) @(negedge clk);
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) bit_out(b[i]);
    endtask

    task automatic begin_cmd();
        @(negedge clk); cs_n = 1'b0;
        repeat (2*HALF) @(negedge clk);
    endtask

    task automatic end_cmd();
        @(negedge clk); sck = 1'b0;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (4*HALF) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] op);
        begin_cmd(); send(op, 8); end_cmd();
    endtask

    task automatic stat_write(input logic [7:0] d);
        begin_cmd(); send(8'h01, 8); send(d, 8); end_cmd();
    endtask

    // driver: pushes one expected byte per status byte read
    task automatic stat_read(input int n, input logic [7:0] expv, input string tag);
        begin_cmd();
        send(8'h05, 8);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(expv);
            tag_q.push_back(tag);
            send(8'h00, 8);
        end
        end_cmd();
    endtask

    // monitor: assembles SO bits and compares against the scoreboard
    always @(posedge sck) begin
        if (!cs_n && so_oe) begin
            acc = {acc[6:0], so};
            nb++;
            if (nb == 8) begin
                nb = 0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected byte", int'(acc), 0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(acc === e, t, int'(acc), int'(e));
                end
            end
        end
    end

    always @(posedge cs_n) nb = 0;
    always @(posedge clk) if (so_oe) oe_cnt++;

    initial begin
        int oe_before;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk_regs(6'b0, "R1 reset fields");
        chk(so_oe === 1'b0, "R1 reset so_oe", int'(so_oe), 0);

        // chip select low since reset: opcode must not run
        repeat (2*HALF) @(negedge clk);
        send(8'h06, 8); end_cmd();
        chk(wr_en_latch === 1'b0, "R2 no command before first CS fall", int'(wr_en_latch), 0);

        cmd(8'h06);
        chk(wr_en_latch === 1'b1, "R3 latch set opcode", int'(wr_en_latch), 1);
        cmd(8'h04);
        chk(wr_en_latch === 1'b0, "R3 latch clear opcode", int'(wr_en_latch), 0);

        stat_write(8'hBC);
        chk_regs(6'b0, "R8 write with latch clear ignored");

        cmd(8'h06);
        stat_write(8'hB4);
        chk_regs(6'b1_11_01_0, "R6 R7 status write applied, latch cleared");

        stat_read(3, 8'hB4, "R5 R4 repeated status byte");
        cmd(8'h06);
        stat_read(1, 8'hB6, "R4 status byte with latch");
        chk(so_oe === 1'b0, "R4 so_oe low when deselected", int'(so_oe), 0);

        wp_n = 1'b0;
        stat_write(8'h08);
        chk_regs(6'b1_11_01_0, "R9 locked write ignored, R7 latch cleared");

        wp_n = 1'b1;
        cmd(8'h06);
        stat_write(8'h08);
        chk_regs(6'b0_00_10_0, "R6 unlocked write applied");

        cmd(8'h06);
        begin_cmd(); send(8'h01, 8); send(8'hFC, 5); end_cmd();
        chk_regs(6'b0_00_10_1, "R10 partial data byte discarded");
        begin_cmd(); send(8'h04, 5); end_cmd();
        chk(wr_en_latch === 1'b1, "R10 partial opcode discarded", int'(wr_en_latch), 1);

        begin_cmd(); send(8'h01, 8); send(8'hFC, 8); send(8'h00, 1); end_cmd();
        chk_regs(6'b0_00_10_1, "R11 extra clock cancels write");

        oe_before = oe_cnt;
        begin_cmd(); send(8'h03, 8); send(8'hFF, 8); end_cmd();
        chk_regs(6'b0_00_10_1, "R12 unknown opcode no state change");
        chk(oe_cnt == oe_before, "R12 unknown opcode never drives so", oe_cnt - oe_before, 0);

        stat_read(2, 8'h0A, "R5 R4 final status bytes");
        chk(exp_q.size() == 0, "R5 all expected bytes received", exp_q.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule